// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a host bus and the control logic of a byte-wide NOR-style flash device. It watches qualified bus write cycles (chip enable low, write enable low, output enable high, all sampled on the system clock). It checks each write against the fixed unlock and setup sequences that guard every flash operation. When a sequence completes, it emits a single-clock command pulse together with the address and data byte latched from the last write.

The recognised commands are reset, read-identifier, byte program, chip erase, sector erase, erase suspend, erase resume and protect unlock. Two busy inputs from the operation engine restrict what is accepted while a program or an erase runs. A third input marks an erase that is held in suspension.

The block also keeps the identifier mode that a read-identifier command enters. While that mode is active, it tells the read path to return an identifier byte or a protection flag instead of array data. It supplies that byte itself.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset no command pulse is active and `rd_sel` is 00 (array data).
- R2: The write sequence AAh@555h, 55h@2AAh, A0h@555h followed by any write gives one `cmd_program` pulse carrying that final write's address and data. Only address bits 10:0 are compared in the unlock cycles, so the upper bits may hold any value.
- R3: AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h gives one `cmd_chip_erase` pulse.
- R4: The same first five cycles followed by 30h at any address give one `cmd_sector_erase` pulse whose `cmd_addr` is that sixth address.
- R5: The same first five cycles followed by 20h@555h give one `cmd_prot_unlock` pulse.
- R6: AAh@555h, 55h@2AAh, 90h@555h gives a `cmd_read_id` pulse and enters identifier mode. In that mode a read with address bits 1:0 = 00 gives `rd_sel`=01 with `rd_id`=C2h. With bits 1:0 = 01 it gives the device code: B0h when TOP_BOOT=1, 34h when TOP_BOOT=0.
- R7: In identifier mode a read with address bit 1 = 1 gives `rd_sel`=10 and `rd_id` = 01h if `sect_prot` is high, 00h if it is low.
- R8: A single F0h write from the idle step, or F0h@555h as the third cycle of an unlock sequence, gives a `cmd_reset` pulse and returns `rd_sel` to 00.
- R9: A write with the wrong address or data for the current step produces no command. It returns the decoder to its first step and clears identifier mode, and a full sequence written afterwards is decoded normally.
- R10: While `busy_prog` is high every write is ignored. No pulse is produced and the sequence step does not move.
- R11: While `busy_erase` is high and `erase_held` is low, only a B0h write (any address) is accepted, giving `cmd_suspend`. All other writes are ignored.
- R12: While `erase_held` is high, a single 30h write gives `cmd_resume` and the program sequence is accepted, but the 80h erase setup is rejected. When `erase_held` is low a lone 30h write gives no pulse.
- R13: Command pulses last exactly one clock and at most one is active at a time. A write strobe taken while `bus_oe_n` is low is not a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_ce_n | input | 1 | Chip enable, active low |
| bus_oe_n | input | 1 | Output enable, active low |
| bus_we_n | input | 1 | Write enable, active low |
| bus_addr | input | AW | Bus address |
| bus_wdata | input | 8 | Bus write data |
| busy_prog | input | 1 | A byte program is running |
| busy_erase | input | 1 | An erase is running |
| erase_held | input | 1 | The running erase is suspended |
| sect_prot | input | 1 | Protection flag of the sector addressed by `bus_addr` |
| cmd_reset | output | 1 | Reset command pulse |
| cmd_read_id | output | 1 | Read-identifier command pulse |
| cmd_program | output | 1 | Program command pulse |
| cmd_chip_erase | output | 1 | Chip erase command pulse |
| cmd_sector_erase | output | 1 | Sector erase command pulse |
| cmd_suspend | output | 1 | Erase suspend command pulse |
| cmd_resume | output | 1 | Erase resume command pulse |
| cmd_prot_unlock | output | 1 | Protect unlock command pulse |
| cmd_addr | output | AW | Address of the write that completed the command |
| cmd_data | output | 8 | Data of the write that completed the command |
| rd_sel | output | 2 | Read source: 00 array, 01 identifier code, 10 protect flag |
| rd_id | output | 8 | Identifier or protect byte for the current address |

## Verification
The bench drives unlock cycles with junk in the upper address bits. A decoder that compared the full address would then never issue a command. It breaks a sequence midway while in identifier mode, which exposes a design that keeps its step or its mode after a bad cycle. It also writes complete sequences while each busy input is raised, which catches a design that lets program, erase or reset commands through during an operation or lets its step advance. In the suspended state it tries an erase setup and a lone resume, and it tries a resume while nothing is suspended; each should reject what it must, and a design that confused the held and running cases would pulse the wrong command. It also checks the decoder reads the sixth sector-erase address rather than the unlock address. A write strobe with output enable low must not count as a write.

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int AW       = 18,
  parameter int KEY_W    = 11,
  parameter bit TOP_BOOT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_ce_n,
  input  logic          bus_oe_n,
  input  logic          bus_we_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  input  logic          busy_prog,
  input  logic          busy_erase,
  input  logic          erase_held,
  input  logic          sect_prot,
  output logic          cmd_reset,
  output logic          cmd_read_id,
  output logic          cmd_program,
  output logic          cmd_chip_erase,
  output logic          cmd_sector_erase,
  output logic          cmd_suspend,
  output logic          cmd_resume,
  output logic          cmd_prot_unlock,
  output logic [AW-1:0] cmd_addr,
  output logic [7:0]    cmd_data,
  output logic [1:0]    rd_sel,
  output logic [7:0]    rd_id
);

  localparam logic [KEY_W-1:0] KEY_A = KEY_W'('h555);
  localparam logic [KEY_W-1:0] KEY_B = KEY_W'('h2AA);
  localparam logic [7:0] MFR_CODE = 8'hC2;
  localparam logic [7:0] DEV_CODE = TOP_BOOT ? 8'hB0 : 8'h34;
  localparam int NCMD  = 8;
  localparam int P_RST = 7, P_RID = 6, P_PGM = 5, P_CHP = 4,
                 P_SEC = 3, P_SUS = 2, P_RES = 1, P_UNL = 0;

  typedef enum logic [2:0] {S_IDLE, S_U1, S_U2, S_PGM, S_E3, S_E4, S_E5} step_t;

  step_t step_q, step_d;
  logic idm_q, idm_d;
  logic wr, wr_q, done;
  logic [AW-1:0] addr_l;
  logic [7:0] data_l;
  logic [NCMD-1:0] pulse_q, pulse_d;
  logic at_a, at_b;

  assign wr   = !bus_ce_n && !bus_we_n && bus_oe_n;
  assign done = wr_q && !wr;
  assign at_a = addr_l[KEY_W-1:0] == KEY_A;
  assign at_b = addr_l[KEY_W-1:0] == KEY_B;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      addr_l <= '0;
      data_l <= '0;
    end else begin
      wr_q <= wr;
      if (wr) begin
        addr_l <= bus_addr;
        data_l <= bus_wdata;
      end
    end
  end

  always_comb begin
    step_d  = step_q;
    idm_d   = idm_q;
    pulse_d = '0;
    if (done && !busy_prog) begin
      if (busy_erase && !erase_held) begin
        if (data_l == 8'hB0) pulse_d[P_SUS] = 1'b1;
      end else begin
        step_d = S_IDLE;
        case (step_q)
          S_IDLE: begin
            if (at_a && data_l == 8'hAA) begin
              step_d = S_U1;
            end else if (data_l == 8'hF0) begin
              pulse_d[P_RST] = 1'b1;
              idm_d = 1'b0;
            end else if (data_l == 8'h30) begin
              if (erase_held) pulse_d[P_RES] = 1'b1;
            end else if (data_l != 8'hB0) begin
              idm_d = 1'b0;
            end
          end
          S_U1: begin
            if (at_b && data_l == 8'h55) step_d = S_U2;
            else idm_d = 1'b0;
          end
          S_U2: begin
            if (at_a && data_l == 8'hA0) begin
              step_d = S_PGM;
            end else if (at_a && data_l == 8'h90) begin
              pulse_d[P_RID] = 1'b1;
              idm_d = 1'b1;
            end else if (at_a && data_l == 8'hF0) begin
              pulse_d[P_RST] = 1'b1;
              idm_d = 1'b0;
            end else if (at_a && data_l == 8'h80 && !erase_held) begin
              step_d = S_E3;
            end else begin
              idm_d = 1'b0;
            end
          end
          S_PGM: begin
            pulse_d[P_PGM] = 1'b1;
            idm_d = 1'b0;
          end
          S_E3: begin
            if (at_a && data_l == 8'hAA) step_d = S_E4;
            else idm_d = 1'b0;
          end
          S_E4: begin
            if (at_b && data_l == 8'h55) step_d = S_E5;
            else idm_d = 1'b0;
          end
          S_E5: begin
            idm_d = 1'b0;
            if (data_l == 8'h30) pulse_d[P_SEC] = 1'b1;
            else if (at_a && data_l == 8'h10) pulse_d[P_CHP] = 1'b1;
            else if (at_a && data_l == 8'h20) pulse_d[P_UNL] = 1'b1;
          end
          default: idm_d = 1'b0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q   <= S_IDLE;
      idm_q    <= 1'b0;
      pulse_q  <= '0;
      cmd_addr <= '0;
      cmd_data <= '0;
    end else begin
      step_q  <= step_d;
      idm_q   <= idm_d;
      pulse_q <= pulse_d;
      if (done) begin
        cmd_addr <= addr_l;
        cmd_data <= data_l;
      end
    end
  end

  assign {cmd_reset, cmd_read_id, cmd_program, cmd_chip_erase,
          cmd_sector_erase, cmd_suspend, cmd_resume, cmd_prot_unlock} = pulse_q;

  assign rd_sel = !idm_q ? 2'b00 : (bus_addr[1] ? 2'b10 : 2'b01);
  assign rd_id  = bus_addr[1] ? {7'b0, sect_prot} : (bus_addr[0] ? DEV_CODE : MFR_CODE);

  a_r13_one_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pulse_q));

  a_r13_single_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q != '0) |=> (pulse_q == '0));

  a_r13_cmd_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q != '0) |-> $past(done));

  a_r9_step_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q != '0) |-> (step_q == S_IDLE));

  a_r10_prog_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (done && busy_prog) |=> (pulse_q == '0) && $stable(step_q) && $stable(idm_q));

  a_r11_only_suspend: assert property (@(posedge clk) disable iff (!rst_n)
    (done && busy_erase && !erase_held && !busy_prog) |=> !cmd_reset && !cmd_read_id
      && !cmd_program && !cmd_chip_erase && !cmd_sector_erase && !cmd_resume && !cmd_prot_unlock);

  a_r12_no_erase_when_held: assert property (@(posedge clk) disable iff (!rst_n)
    (done && erase_held) |=> !cmd_chip_erase && !cmd_sector_erase && !cmd_prot_unlock);

endmodule

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;
  localparam int AW = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic busy_prog = 1'b0, busy_erase = 1'b0, erase_held = 1'b0, sect_prot = 1'b0;
  logic c_rst, c_rid, c_pgm, c_chp, c_sec, c_sus, c_res, c_unl;
  logic [AW-1:0] c_addr;
  logic [7:0] c_data;
  logic [1:0] rd_sel;
  logic [7:0] rd_id;
  logic [7:0] got;
  int checks = 0;
  int errors = 0;

  localparam logic [7:0] V_RST = 8'h80, V_RID = 8'h40, V_PGM = 8'h20, V_CHP = 8'h10,
                         V_SEC = 8'h08, V_SUS = 8'h04, V_RES = 8'h02, V_UNL = 8'h01;

  always #2.5 clk = ~clk;

  flash_cmd_decoder u0 (
    .clk(clk), .rst_n(rst_n), .bus_ce_n(ce_n), .bus_oe_n(oe_n), .bus_we_n(we_n),
    .bus_addr(addr), .bus_wdata(wdata), .busy_prog(busy_prog), .busy_erase(busy_erase),
    .erase_held(erase_held), .sect_prot(sect_prot),
    .cmd_reset(c_rst), .cmd_read_id(c_rid), .cmd_program(c_pgm), .cmd_chip_erase(c_chp),
    .cmd_sector_erase(c_sec), .cmd_suspend(c_sus), .cmd_resume(c_res),
    .cmd_prot_unlock(c_unl), .cmd_addr(c_addr), .cmd_data(c_data),
    .rd_sel(rd_sel), .rd_id(rd_id)
  );

  function automatic logic [7:0] pv();
    return {c_rst, c_rid, c_pgm, c_chp, c_sec, c_sus, c_res, c_unl};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bw_oe(input logic [AW-1:0] a, input logic [7:0] d, input logic oe);
    @(negedge clk);
    addr = a; wdata = d; ce_n = 1'b0; we_n = 1'b0; oe_n = oe;
    @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
    got = pv();
  endtask

  task automatic bw(input logic [AW-1:0] a, input logic [7:0] d);
    bw_oe(a, d, 1'b1);
  endtask

  task automatic rd(input logic [AW-1:0] a);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    #1;
  endtask

  task automatic rd_end();
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic unlock3(input logic [7:0] third);
    bw(18'h3C555, 8'hAA);
    bw(18'h102AA, 8'h55);
    bw(18'h00555, third);
  endtask

  task automatic erase_pre();
    unlock3(8'h80);
    bw(18'h2A555, 8'hAA);
    bw(18'h052AA, 8'h55);
  endtask

  task automatic t_reset();
    rd(18'h0);
    chk("R1 no pulse after reset", pv(), 8'h00);
    chk("R1 array select after reset", rd_sel, 2'b00);
    rd_end();
  endtask

  task automatic t_program();
    unlock3(8'hA0);
    chk("R2 no pulse before data cycle", got, 8'h00);
    bw(18'h12345, 8'h5A);
    chk("R2 program pulse", got, V_PGM);
    chk("R2 program address", c_addr, 18'h12345);
    chk("R2 program data", c_data, 8'h5A);
    @(negedge clk);
    chk("R13 pulse lasts one clock", pv(), 8'h00);
  endtask

  task automatic t_erase();
    erase_pre();
    bw(18'h20555, 8'h10);
    chk("R3 chip erase pulse", got, V_CHP);
    erase_pre();
    bw(18'h2C123, 8'h30);
    chk("R4 sector erase pulse", got, V_SEC);
    chk("R4 sector address", c_addr, 18'h2C123);
    erase_pre();
    bw(18'h00555, 8'h20);
    chk("R5 protect unlock pulse", got, V_UNL);
  endtask

  task automatic t_ident();
    unlock3(8'h90);
    chk("R6 read id pulse", got, V_RID);
    rd(18'h0);
    chk("R6 id select", rd_sel, 2'b01);
    chk("R6 manufacturer code", rd_id, 8'hC2);
    rd(18'h1);
    chk("R6 device code", rd_id, 8'hB0);
    sect_prot = 1'b1;
    rd(18'h22002);
    chk("R7 protect select", rd_sel, 2'b10);
    chk("R7 protected flag", rd_id, 8'h01);
    sect_prot = 1'b0;
    #1;
    chk("R7 unprotected flag", rd_id, 8'h00);
    rd_end();
    bw(18'h3FFFF, 8'hF0);
    chk("R8 single reset pulse", got, V_RST);
    rd(18'h0);
    chk("R8 back to array", rd_sel, 2'b00);
    rd_end();
    unlock3(8'h90);
    unlock3(8'hF0);
    chk("R8 three-cycle reset pulse", got, V_RST);
    rd(18'h1);
    chk("R8 array after three-cycle reset", rd_sel, 2'b00);
    rd_end();
  endtask

  task automatic t_wrong();
    unlock3(8'h90);
    bw(18'h00555, 8'hAA);
    bw(18'h002AB, 8'h55);
    chk("R9 wrong address gives no pulse", got, 8'h00);
    rd(18'h0);
    chk("R9 wrong cycle leaves id mode", rd_sel, 2'b00);
    rd_end();
    bw(18'h00555, 8'hA0);
    bw(18'h00100, 8'h11);
    chk("R9 no program from stale step", got, 8'h00);
    bw(18'h00555, 8'hAA);
    bw(18'h002AA, 8'h54);
    bw(18'h00555, 8'hA0);
    chk("R9 wrong data gives no pulse", got, 8'h00);
    unlock3(8'hA0);
    bw(18'h00200, 8'h22);
    chk("R9 full sequence after error", got, V_PGM);
  endtask

  task automatic t_busy_prog();
    busy_prog = 1'b1;
    unlock3(8'hA0);
    bw(18'h00300, 8'h33);
    chk("R10 program ignored while busy", got, 8'h00);
    bw(18'h00000, 8'hF0);
    chk("R10 reset ignored while busy", got, 8'h00);
    bw(18'h00555, 8'hAA);
    busy_prog = 1'b0;
    bw(18'h002AA, 8'h55);
    bw(18'h00555, 8'h90);
    chk("R10 step did not advance while busy", got, 8'h00);
  endtask

  task automatic t_busy_erase();
    busy_erase = 1'b1;
    unlock3(8'hF0);
    chk("R11 reset ignored while erasing", got, 8'h00);
    bw(18'h1ABCD, 8'hB0);
    chk("R11 suspend accepted", got, V_SUS);
    bw(18'h00000, 8'h30);
    chk("R11 resume ignored while running", got, 8'h00);
    busy_erase = 1'b0;
  endtask

  task automatic t_held();
    bw(18'h00000, 8'h30);
    chk("R12 resume without suspension", got, 8'h00);
    busy_erase = 1'b1;
    erase_held = 1'b1;
    bw(18'h00000, 8'h30);
    chk("R12 resume pulse", got, V_RES);
    unlock3(8'hA0);
    bw(18'h00400, 8'h44);
    chk("R12 program while held", got, V_PGM);
    erase_pre();
    bw(18'h00555, 8'h10);
    chk("R12 chip erase rejected while held", got, 8'h00);
    erase_held = 1'b0;
    busy_erase = 1'b0;
  endtask

  task automatic t_oe();
    unlock3(8'h90);
    bw_oe(18'h00000, 8'hF0, 1'b0);
    chk("R13 strobe with oe low not a write", got, 8'h00);
    rd(18'h0);
    chk("R13 id mode kept", rd_sel, 2'b01);
    rd_end();
    bw(18'h00000, 8'hF0);
  endtask

  initial begin : watchdog
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_erase();
    t_ident();
    t_wrong();
    t_busy_prog();
    t_busy_erase();
    t_held();
    t_oe();
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule